// File: doc/BRIEF.md
# Slotted Instruction Fetch and Branch Unit

This block is the sequencing front end of a small stack processor. It fetches a 20-bit program word that packs four 5-bit instruction slots, hands the slots to the execute stage one per cycle, and tells the rest of the core whether each opcode takes a memory cycle. It owns the program pointer P and the address register A. It also chooses what drives the 21-bit memory address bus: P, a branch target, the return-stack top supplied by the core, or A. One incrementer sits on the bus at all times. Its result is written back to P after instruction and literal reads, and to A after post-increment data accesses.

Jump, call and the two conditional branches take their target from the slots that follow them in the same word, with the high bits taken from P. The target is driven onto the bus directly and the word at the target is fetched in the same cycle. P receives the target plus one. When P lies in the byte region (address bit 20 clear), a fetch keeps only the low 8 data bits. The upper 12 instruction bits are filled from the address lines, and only the last slot is executed. Reset starts execution in the byte region so that a short boot routine can run there. It leaves the byte region with a return to a word address.

Top module: `slot_seq_unit`

## Requirements
- R1: While reset is active and in the cycle after it is released, the unit is in its fetch state with P = 0: mem_addr = 0, mem_req = 1 and exec_valid = 0.
- R2: Opcode encoding: 00 jump, 01 branch-if-T-zero, 02 call, 03 branch-if-T-positive (T bit 19 clear), 04 return, 08 read at A, 09 read at A then A+1, 0A literal, 0C write at A, 0D write at A then A+1. Every other code below 10 reads at A. Codes 10 to 1F make no bus access. exec_mem is high exactly when opcode bit 4 is clear.
- R3: A word-region fetch loads all 20 data bits. Slots are executed in the order bits 19:15, 14:10, 9:5, 4:0, one per cycle, numbered 0 to 3 on exec_slot. After slot 3 the next word is fetched from the incremented P.
- R4: A byte-region fetch loads data bits 7:0 into instruction bits 7:0 and address bits 19:8 into instruction bits 19:8. Only slot 3 is executed, and then the next fetch follows.
- R5: In the byte region the branch target is {P[20:15], instruction bits 14:0}, so a branch opcode reaches at most 8 targets chosen by data bits 7:5.
- R6: A taken branch in slot 0 targets {P[20:15], slots 1 to 3}. The target drives mem_addr with mem_req in that same cycle, the word there is loaded, and P becomes target + 1.
- R7: Branch-if-T-zero is taken when t_top is 0. When it is not taken there is no bus access in that cycle, the remaining slots are skipped, and the next word is fetched from P.
- R8: Branch-if-T-positive is taken when t_top bit 19 is 0. When not taken it behaves as in R7.
- R9: A branch in slot k > 0 takes its low 5*(3-k) target bits from the slots after it and the rest from P. In slot 3 the target equals P.
- R10: A call raises rpush with rpush_val equal to the address of the word after the call. A return drives mem_addr from rtop, raises rpop and loads the word there.
- R11: A literal reads at P and advances P. Accesses at A drive mem_addr = A, writes raise mem_we, and post-increment forms add one to A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | 20 | Read data from memory, valid in the cycle of the request |
| t_top | input | 20 | Top of data stack, used for conditional branches |
| rtop | input | 21 | Top of return stack, used by return |
| a_wr | input | 1 | Load A from a_wdata |
| a_wdata | input | 21 | New value for A |
| mem_addr | output | 21 | Memory address bus |
| mem_req | output | 1 | Memory cycle this clock |
| mem_we | output | 1 | Memory cycle is a write |
| exec_valid | output | 1 | An opcode is being executed |
| exec_op | output | 5 | Opcode being executed |
| exec_slot | output | 2 | Slot index of that opcode |
| exec_mem | output | 1 | Opcode takes a memory cycle |
| rpush | output | 1 | Push rpush_val onto the return stack |
| rpush_val | output | 21 | Return address for a call |
| rpop | output | 1 | Pop the return stack |

## Verification
The bench boots from the byte region, where noise in the upper data bits must not reach the decoder. A branch there must form its target from the address lines and not from the data bus. A return then moves execution into word memory. It runs both conditional branches taken and not taken. A unit that kept decoding the target slots after a failed branch would show extra exec cycles instead of a fetch from the next word. Branches in slots 2 and 3 catch a target former that always uses three slots. Post-increment reads and writes followed by plain accesses at A show whether the shared incrementer was written back to A rather than to P.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

    typedef enum logic [0:0] {
        ST_FETCH = 1'b0,
        ST_EXEC  = 1'b1
    } seq_state_e;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_BR   = 3'd1,
        K_RET  = 3'd2,
        K_LIT  = 3'd3,
        K_MEM  = 3'd4
    } op_kind_e;

    localparam logic [4:0] OP_JMP  = 5'h00;
    localparam logic [4:0] OP_BTZ  = 5'h01;
    localparam logic [4:0] OP_CALL = 5'h02;
    localparam logic [4:0] OP_BPOS = 5'h03;
    localparam logic [4:0] OP_RET  = 5'h04;
    localparam logic [4:0] OP_LDA  = 5'h08;
    localparam logic [4:0] OP_LDAI = 5'h09;
    localparam logic [4:0] OP_LIT  = 5'h0A;
    localparam logic [4:0] OP_STA  = 5'h0C;
    localparam logic [4:0] OP_STAI = 5'h0D;

endpackage

// File: rtl/slot_seq_decode.sv
module slot_seq_decode
    import slot_seq_pkg::*;
#(
    parameter int unsigned DW    = 20,
    parameter int unsigned SW    = 5,
    parameter int unsigned NSLOT = 4,
    localparam int unsigned SLW  = $clog2(NSLOT)
) (
    input  logic [DW-1:0]  ir,
    input  logic [SLW-1:0] slot,
    output logic [SW-1:0]  op,
    output op_kind_e       kind,
    output logic           post_inc,
    output logic           is_store
);

    logic [SW-1:0] slot_ops [NSLOT];

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign slot_ops[k] = ir[DW-1-SW*k -: SW];
    end

    always_comb begin
        op = slot_ops[0];
        for (int k = 1; k < NSLOT; k++) begin
            if (slot == SLW'(k)) begin
                op = slot_ops[k];
            end
        end
    end

    always_comb begin
        post_inc = 1'b0;
        is_store = 1'b0;
        if (op[SW-1]) begin
            kind = K_NONE;
        end else begin
            case (op)
                OP_JMP, OP_BTZ, OP_CALL, OP_BPOS: kind = K_BR;
                OP_RET:                           kind = K_RET;
                OP_LIT:                           kind = K_LIT;
                default:                          kind = K_MEM;
            endcase
            post_inc = (op == OP_LDAI) || (op == OP_STAI);
            is_store = (op == OP_STA)  || (op == OP_STAI);
        end
    end

endmodule

// File: rtl/slot_seq_target.sv
module slot_seq_target #(
    parameter int unsigned AW    = 21,
    parameter int unsigned DW    = 20,
    parameter int unsigned SW    = 5,
    parameter int unsigned NSLOT = 4,
    localparam int unsigned SLW  = $clog2(NSLOT)
) (
    input  logic [AW-1:0]  p,
    input  logic [DW-1:0]  ir,
    input  logic [SLW-1:0] slot,
    input  logic           byte_mode,
    output logic [AW-1:0]  target
);

    logic [AW-1:0] cand [NSLOT];

    for (genvar k = 0; k < NSLOT; k++) begin : g_cand
        localparam int unsigned NB = SW * (NSLOT - 1 - k);
        if (NB == 0) begin : g_from_p
            assign cand[k] = p;
        end else begin : g_mixed
            assign cand[k] = {p[AW-1:NB], ir[NB-1:0]};
        end
    end

    always_comb begin
        target = cand[0];
        if (!byte_mode) begin
            for (int k = 1; k < NSLOT; k++) begin
                if (slot == SLW'(k)) begin
                    target = cand[k];
                end
            end
        end
    end

endmodule

// File: rtl/slot_seq_incr.sv
module slot_seq_incr #(
    parameter int unsigned AW = 21
) (
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] addr_inc
);

    assign addr_inc = addr + AW'(1);

endmodule

// File: rtl/slot_seq_unit.sv
module slot_seq_unit
    import slot_seq_pkg::*;
#(
    parameter int unsigned AW     = 21,
    parameter int unsigned DW     = 20,
    parameter int unsigned SW     = 5,
    parameter int unsigned NSLOT  = 4,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned SLW   = $clog2(NSLOT)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  mem_rdata,
    input  logic [DW-1:0]  t_top,
    input  logic [AW-1:0]  rtop,
    input  logic           a_wr,
    input  logic [AW-1:0]  a_wdata,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_req,
    output logic           mem_we,
    output logic           exec_valid,
    output logic [SW-1:0]  exec_op,
    output logic [SLW-1:0] exec_slot,
    output logic           exec_mem,
    output logic           rpush,
    output logic [AW-1:0]  rpush_val,
    output logic           rpop
);

    localparam logic [SLW-1:0] LAST_SLOT = SLW'(NSLOT - 1);

    typedef struct packed {
        seq_state_e     state;
        logic [AW-1:0]  p;
        logic [AW-1:0]  a;
        logic [DW-1:0]  ir;
        logic [SLW-1:0] slot;
        logic           byte_m;
    } seq_regs_t;

    seq_regs_t regs_d, regs_q;

    logic [SW-1:0] op;
    op_kind_e      kind;
    logic          post_inc;
    logic          is_store;
    logic [AW-1:0] target;
    logic [AW-1:0] addr_inc;
    logic          taken;
    logic          load_ir;
    logic          advance;
    logic          byte_mode;

    slot_seq_decode #(.DW(DW), .SW(SW), .NSLOT(NSLOT)) i_decode (
        .ir       (regs_q.ir),
        .slot     (regs_q.slot),
        .op       (op),
        .kind     (kind),
        .post_inc (post_inc),
        .is_store (is_store)
    );

    slot_seq_target #(.AW(AW), .DW(DW), .SW(SW), .NSLOT(NSLOT)) i_target (
        .p         (regs_q.p),
        .ir        (regs_q.ir),
        .slot      (regs_q.slot),
        .byte_mode (regs_q.byte_m),
        .target    (target)
    );

    slot_seq_incr #(.AW(AW)) i_incr (
        .addr     (mem_addr),
        .addr_inc (addr_inc)
    );

    assign taken = (op == OP_JMP) || (op == OP_CALL) ||
                   ((op == OP_BTZ)  && (t_top == '0)) ||
                   ((op == OP_BPOS) && !t_top[DW-1]);

    // Bus source selection: P, branch target, return top or A
    always_comb begin
        mem_addr   = regs_q.p;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        exec_valid = 1'b0;
        load_ir    = 1'b0;
        advance    = 1'b0;
        rpush      = 1'b0;
        rpop       = 1'b0;
        if (regs_q.state == ST_FETCH) begin
            mem_req = 1'b1;
            load_ir = 1'b1;
        end else begin
            exec_valid = 1'b1;
            case (kind)
                K_BR: begin
                    if (taken) begin
                        mem_addr = target;
                        mem_req  = 1'b1;
                        load_ir  = 1'b1;
                        rpush    = (op == OP_CALL);
                    end
                end
                K_RET: begin
                    mem_addr = rtop;
                    mem_req  = 1'b1;
                    load_ir  = 1'b1;
                    rpop     = 1'b1;
                end
                K_LIT: begin
                    mem_req = 1'b1;
                    advance = 1'b1;
                end
                K_MEM: begin
                    mem_addr = regs_q.a;
                    mem_req  = 1'b1;
                    mem_we   = is_store;
                    advance  = 1'b1;
                end
                default: begin
                    advance = 1'b1;
                end
            endcase
        end
    end

    // Next-state computation
    always_comb begin
        regs_d = regs_q;
        if ((regs_q.state == ST_EXEC) && (kind == K_BR) && !taken) begin
            regs_d.state = ST_FETCH;
        end
        if ((regs_q.state == ST_EXEC) && (kind == K_LIT)) begin
            regs_d.p = addr_inc;
        end
        if ((regs_q.state == ST_EXEC) && (kind == K_MEM) && post_inc) begin
            regs_d.a = addr_inc;
        end
        if (advance) begin
            if ((regs_q.slot == LAST_SLOT) || regs_q.byte_m) begin
                regs_d.state = ST_FETCH;
            end else begin
                regs_d.slot = regs_q.slot + SLW'(1);
            end
        end
        if (load_ir) begin
            regs_d.state  = ST_EXEC;
            regs_d.p      = addr_inc;
            regs_d.byte_m = !mem_addr[AW-1];
            if (mem_addr[AW-1]) begin
                regs_d.ir   = mem_rdata;
                regs_d.slot = '0;
            end else begin
                regs_d.ir   = {mem_addr[DW-1:BYTE_W], mem_rdata[BYTE_W-1:0]};
                regs_d.slot = LAST_SLOT;
            end
        end
        if (a_wr) begin
            regs_d.a = a_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.state  <= ST_FETCH;
            regs_q.p      <= '0;
            regs_q.a      <= '0;
            regs_q.ir     <= '0;
            regs_q.slot   <= '0;
            regs_q.byte_m <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign exec_op   = op;
    assign exec_slot = regs_q.slot;
    assign exec_mem  = !op[SW-1];
    assign rpush_val = regs_q.p;
    assign byte_mode = regs_q.byte_m;

endmodule

// File: rtl/slot_seq_chk.sv
module slot_seq_chk
    import slot_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        exec_valid,
    input logic [4:0]  exec_op,
    input logic [1:0]  exec_slot,
    input logic        exec_mem,
    input logic        mem_req,
    input logic        mem_we,
    input logic [19:0] t_top,
    input logic        rpush,
    input logic        rpop,
    input logic        byte_mode
);

    p_mem_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> (exec_mem == !exec_op[4]));

    p_fetch_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_slot == 2'd3 && exec_op[4]) |=> !exec_valid);

    p_byte_last_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && byte_mode) |-> (exec_slot == 2'd3));

    p_btz_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_op == OP_BTZ && t_top != '0) |-> (!mem_req ##1 !exec_valid));

    p_bpos_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_op == OP_BPOS && !t_top[19]) |-> (mem_req && !mem_we));

    p_stack_ops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rpush || rpop) |-> (mem_req && !mem_we && !(rpush && rpop)));

    p_write_in_exec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && exec_valid && exec_mem));

    p_idle_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_op[4]) |-> !mem_req);

endmodule

bind slot_seq_unit slot_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_valid (exec_valid),
    .exec_op    (exec_op),
    .exec_slot  (exec_slot),
    .exec_mem   (exec_mem),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .t_top      (t_top),
    .rpush      (rpush),
    .rpop       (rpop),
    .byte_mode  (byte_mode)
);

// File: tb/test_slot_seq_unit.sv
module test_slot_seq_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] mem_rdata;
    logic [19:0] t_top;
    logic [20:0] rtop;
    logic        a_wr;
    logic [20:0] a_wdata;
    logic [20:0] mem_addr;
    logic        mem_req;
    logic        mem_we;
    logic        exec_valid;
    logic [4:0]  exec_op;
    logic [1:0]  exec_slot;
    logic        exec_mem;
    logic        rpush;
    logic [20:0] rpush_val;
    logic        rpop;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [19:0] wmem [256];
    logic [7:0]  bmem [256];

    always #2.5 clk = ~clk;

    always_comb begin
        if (mem_addr[20]) mem_rdata = wmem[mem_addr[7:0]];
        else              mem_rdata = {12'hC3A, bmem[mem_addr[7:0]]};
    end

    slot_seq_unit i_slot_seq_unit (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .t_top(t_top),
        .rtop(rtop), .a_wr(a_wr), .a_wdata(a_wdata), .mem_addr(mem_addr),
        .mem_req(mem_req), .mem_we(mem_we), .exec_valid(exec_valid),
        .exec_op(exec_op), .exec_slot(exec_slot), .exec_mem(exec_mem),
        .rpush(rpush), .rpush_val(rpush_val), .rpop(rpop)
    );

    function automatic logic [19:0] wrd(input logic [4:0] s0, s1, s2, s3);
        return {s0, s1, s2, s3};
    endfunction

    function automatic logic [19:0] brw(input logic [4:0] op, input logic [14:0] tgt);
        return {op, tgt};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_exec(input string req, input logic [4:0] op, input logic [1:0] slot);
        chk({req, " exec_valid"}, 32'(exec_valid), 32'd1);
        chk({req, " op"}, 32'(exec_op), 32'(op));
        chk({req, " slot"}, 32'(exec_slot), 32'(slot));
    endtask

    task automatic chk_fetch(input string req, input logic [20:0] addr);
        chk({req, " fetch idle"}, 32'(exec_valid), 32'd0);
        chk({req, " fetch addr"}, 32'(mem_addr), 32'(addr));
        chk({req, " fetch req"}, 32'(mem_req), 32'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; t_top = '0; rtop = '0; a_wr = 1'b0; a_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        a_wr = 1'b1; a_wdata = 21'h100030;
        #1;
        chk_fetch("R1", 21'h0);
    endtask

    task automatic t_byte_boot();
        tick();
        a_wr = 1'b0;
        #1;
        chk_exec("R4", 5'h00, 2'd3);
        chk("R5 byte target", 32'(mem_addr), 32'h0000A0);
        chk("R5 byte req", 32'(mem_req), 32'd1);
        tick();
        rtop = 21'h100010;
        #1;
        chk_exec("R4 ret", 5'h04, 2'd3);
        chk("R10 ret addr", 32'(mem_addr), 32'h100010);
        chk("R10 rpop", 32'(rpop), 32'd1);
    endtask

    task automatic t_slot_walk();
        logic [4:0] ops [4] = '{5'h10, 5'h15, 5'h1A, 5'h1F};
        for (int k = 0; k < 4; k++) begin
            tick();
            #1;
            chk_exec("R3", ops[k], 2'(k));
            chk("R2 class", 32'(exec_mem), 32'd0);
            chk("R2 no req", 32'(mem_req), 32'd0);
        end
        tick();
        #1;
        chk_fetch("R3", 21'h100011);
    endtask

    task automatic t_data_ops();
        tick(); #1;
        chk_exec("R11 lit", 5'h0A, 2'd0);
        chk("R11 lit addr", 32'(mem_addr), 32'h100012);
        chk("R2 lit class", 32'(exec_mem), 32'd1);
        tick(); #1;
        chk("R11 readinc addr", 32'(mem_addr), 32'h100030);
        chk("R11 readinc we", 32'(mem_we), 32'd0);
        tick(); #1;
        chk("R11 writeinc addr", 32'(mem_addr), 32'h100031);
        chk("R11 writeinc we", 32'(mem_we), 32'd1);
        tick(); #1;
        chk_exec("R3 tail", 5'h1F, 2'd3);
        tick(); #1;
        chk_fetch("R11 after lit", 21'h100013);
    endtask

    task automatic t_cond_branches();
        tick(); t_top = 20'h0; #1;
        chk_exec("R7 taken", 5'h01, 2'd0);
        chk("R6 R7 target", 32'(mem_addr), 32'h100040);
        chk("R6 req", 32'(mem_req), 32'd1);
        tick(); t_top = 20'h00005; #1;
        chk_exec("R7 not taken", 5'h01, 2'd0);
        chk("R7 no req", 32'(mem_req), 32'd0);
        tick(); #1;
        chk_fetch("R7 next word", 21'h100041);
        tick(); t_top = 20'h7FFFF; #1;
        chk_exec("R8 taken", 5'h03, 2'd0);
        chk("R8 target", 32'(mem_addr), 32'h100050);
        tick(); t_top = 20'h80000; #1;
        chk_exec("R8 not taken", 5'h03, 2'd0);
        chk("R8 no req", 32'(mem_req), 32'd0);
        tick(); #1;
        chk_fetch("R8 next word", 21'h100051);
    endtask

    task automatic t_call_late_jumps();
        tick(); #1;
        chk_exec("R10 call", 5'h02, 2'd0);
        chk("R10 call target", 32'(mem_addr), 32'h100060);
        chk("R10 rpush", 32'(rpush), 32'd1);
        chk("R10 rpush_val", 32'(rpush_val), 32'h100052);
        tick(); tick(); tick(); #1;
        chk_exec("R9 slot2 jump", 5'h00, 2'd2);
        chk("R9 slot2 target", 32'(mem_addr), 32'h100067);
        tick(); tick(); tick(); tick(); #1;
        chk_exec("R9 slot3 jump", 5'h00, 2'd3);
        chk("R9 slot3 target", 32'(mem_addr), 32'h100068);
        tick(); #1;
        chk_exec("R11 read", 5'h08, 2'd0);
        chk("R11 A after incs", 32'(mem_addr), 32'h100032);
        tick(); #1;
        chk("R11 write addr", 32'(mem_addr), 32'h100032);
        chk("R11 write we", 32'(mem_we), 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            wmem[i] = wrd(5'h1F, 5'h1F, 5'h1F, 5'h1F);
            bmem[i] = 8'hFF;
        end
        bmem[8'h00] = 8'hA0;
        bmem[8'hA0] = 8'h04;
        wmem[8'h10] = wrd(5'h10, 5'h15, 5'h1A, 5'h1F);
        wmem[8'h11] = wrd(5'h0A, 5'h09, 5'h0D, 5'h1F);
        wmem[8'h12] = 20'h12345;
        wmem[8'h13] = brw(5'h01, 15'h0040);
        wmem[8'h40] = brw(5'h01, 15'h0123);
        wmem[8'h41] = brw(5'h03, 15'h0050);
        wmem[8'h50] = brw(5'h03, 15'h0456);
        wmem[8'h51] = brw(5'h02, 15'h0060);
        wmem[8'h60] = wrd(5'h10, 5'h10, 5'h00, 5'h07);
        wmem[8'h67] = wrd(5'h10, 5'h10, 5'h10, 5'h00);
        wmem[8'h68] = wrd(5'h08, 5'h0C, 5'h10, 5'h10);
        t_reset();
        t_byte_boot();
        t_slot_walk();
        t_data_ops();
        t_cond_branches();
        t_call_late_jumps();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule